// File: doc/BRIEF.md
# Fuse Array Program and Read Sequencer

This block is the digital controller in front of a one-time-programmable fuse array. The array is divided into banks of 256 bits, and each fuse is burned or sensed one bit at a time through a simple macro interface. The interface carries a bit address, a program strobe, a sense strobe and the sensed data bit. Software first writes a timing register, which gives the setup/hold count, the program strobe width and the sense strobe width, all in clock cycles. It then loads the program data words or picks read mode, and writes the control register with a bank number, a mode and the start bit.

In program mode the sequencer walks the 256 bit positions of the chosen bank. It skips each position whose data bit is 0. For each position holding a 1, it holds the address for the setup count, pulses the program strobe for the strobe count and holds the address for the hold count. In read mode it senses every bit of the bank with the sense strobe and stores the results in that bank's shadow words. Software reads the shadow words later through the register port. A sticky done flag marks completion. While an operation is running, the configuration is locked against writes. A separate register bit drives the supply-enable output for the analog side.

Top module: `efuse_seq`

## Requirements
- R1: After reset, the status, control and supply registers read 0, all shadow words read 0, and both strobes and the supply-enable output are low.
- R2: Writing the control register (word 0) with bit 0 = 1 starts an operation while the block is idle. Bit 1 selects program (1) or read (0), and bits 9:8 select the bank. The fuse address presented is bank*256 + bit index, and it stays constant while a strobe is high.
- R3: In program mode, a program strobe is issued once for each 1 in the eight program data words (words 8 to 15), and for no 0 bit. Fuses outside those positions never change, and read mode never issues a program strobe.
- R4: A read operation writes the sensed value of every bit of the selected bank into that bank's shadow words, which sit at word 32 + 8*bank + k. The shadow words of the other banks are left unchanged.
- R5: Bit j of program data word k, and bit j of shadow word k, maps to bank bit 32*k + j. Byte 0 of a word is therefore bits 7:0 and byte 3 is bits 31:24.
- R6: Status bit 0 (done) sets when an operation completes. It stays set until software writes the status register (word 1) with bit 0 = 1. Writing 0 there leaves it set.
- R7: The timing register (word 2) holds the setup/hold count in bits 7:0, the program strobe width in bits 23:8 and the sense strobe width in bits 31:24. Each strobe is high for exactly its field value in cycles, and a field of 0 counts as 1.
- R8: The program strobe rises only after the address has been stable for at least the setup count. The address stays stable for at least that count after the strobe falls.
- R9: Status bit 1 reads 1 while an operation runs. Writes to the control, timing and program data registers during that time are ignored, so clearing the start bit mid-operation has no effect.
- R10: Bit 0 of the supply register (word 3) drives the fz_supply_en output directly and is writable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| fz_addr | output | 10 | Fuse bit address: bank and bit index |
| fz_prog | output | 1 | Program (burn) strobe |
| fz_sense | output | 1 | Sense (read) strobe |
| fz_din | input | 1 | Sensed fuse value, valid while fz_sense is high |
| fz_supply_en | output | 1 | Supply enable for the analog side |

## Verification
The assertions check several properties on every cycle:
- a program strobe never meets a 0 data bit;
- the two strobes are never high together, and both are low when idle;
- the address holds while a strobe is high;
- every strobe pulse has exactly the width its timing field gives;
- the bank is locked while busy;
- done is sticky and is set when busy falls.

Other properties need the bench's scenarios, run against a sticky fuse model:
- programmed ones read back into the correct shadow words, and zeros never burn;
- the other banks' shadow words stay untouched;
- the little-endian bit mapping holds;
- writes during an operation are really discarded;
- the setup and hold windows around each strobe are met.

// File: rtl/efuse_seq_pkg.sv
package efuse_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SCAN,
    SQ_SETUP,
    SQ_STROBE,
    SQ_HOLD,
    SQ_FIN
  } sq_state_t;

  // register word addresses
  localparam int unsigned RA_CTRL   = 0;
  localparam int unsigned RA_STAT   = 1;
  localparam int unsigned RA_TIME   = 2;
  localparam int unsigned RA_SUPPLY = 3;
  localparam int unsigned RA_PGM    = 8;
  localparam int unsigned RA_SHADOW = 32;

  // control and status bit positions
  localparam int unsigned CB_GO   = 0;
  localparam int unsigned CB_MODE = 1;
  localparam int unsigned CB_BANK = 8;
  localparam int unsigned SB_DONE = 0;
  localparam int unsigned SB_BUSY = 1;

  // cycles a phase lasts for a timing field value (0 behaves as 1)
  function automatic logic [31:0] phase_len(input logic [31:0] field);
    return (field == 32'd0) ? 32'd1 : field;
  endfunction

  // counter preload for a phase that counts down to zero
  function automatic logic [31:0] phase_load(input logic [31:0] field);
    return phase_len(field) - 32'd1;
  endfunction

endpackage

// File: rtl/efuse_regs.sv
module efuse_regs
  import efuse_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_BITS = 256,
  parameter int SU_W      = 8,
  parameter int PW_W      = 16,
  parameter int RW_W      = 8,
  parameter int ADDR_W    = 6,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 busy,
  input  logic                 seq_done,
  output logic                 start,
  output logic                 cfg_mode,
  output logic [BANK_W-1:0]    cfg_bank,
  output logic [SU_W-1:0]      t_su,
  output logic [PW_W-1:0]      t_pw,
  output logic [RW_W-1:0]      t_rw,
  output logic [BANK_BITS-1:0] pgm_bits,
  output logic                 supply_en,
  output logic                 done_flag,
  output logic                 stat_w1c,
  output logic [31:0]          reg_rdata
);

  localparam int WPB = BANK_BITS / 32;
  localparam int TW  = SU_W + PW_W + RW_W;

  logic              go_q;
  logic [TW-1:0]     time_q;
  logic [31:0]       pgm_w [WPB];

  logic hit_ctrl, hit_stat, hit_time, hit_sup;
  logic cfg_open;

  assign hit_ctrl = bus_addr == ADDR_W'(RA_CTRL);
  assign hit_stat = bus_addr == ADDR_W'(RA_STAT);
  assign hit_time = bus_addr == ADDR_W'(RA_TIME);
  assign hit_sup  = bus_addr == ADDR_W'(RA_SUPPLY);
  assign cfg_open = bus_we && !busy;

  assign start    = cfg_open && hit_ctrl && bus_wdata[CB_GO];
  assign stat_w1c = bus_we && hit_stat && bus_wdata[SB_DONE];

  assign t_su = time_q[SU_W-1:0];
  assign t_pw = time_q[SU_W +: PW_W];
  assign t_rw = time_q[SU_W+PW_W +: RW_W];

  // control register: locked while an operation runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      cfg_mode <= 1'b0;
      cfg_bank <= '0;
    end else if (cfg_open && hit_ctrl) begin
      go_q     <= bus_wdata[CB_GO];
      cfg_mode <= bus_wdata[CB_MODE];
      cfg_bank <= bus_wdata[CB_BANK +: BANK_W];
    end else if (seq_done) begin
      go_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   time_q <= '0;
    else if (cfg_open && hit_time) time_q <= bus_wdata[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  supply_en <= 1'b0;
    else if (bus_we && hit_sup)  supply_en <= bus_wdata[0];
  end

  // sticky done: completion wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (seq_done) done_flag <= 1'b1;
    else if (stat_w1c) done_flag <= 1'b0;
  end

  generate
    for (genvar k = 0; k < WPB; k++) begin : g_pgm
      logic wr_k;
      assign wr_k = cfg_open && (bus_addr == ADDR_W'(RA_PGM + k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pgm_w[k] <= '0;
        else if (wr_k) pgm_w[k] <= bus_wdata;
      end
      assign pgm_bits[32*k +: 32] = pgm_w[k];
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[CB_GO]             = go_q;
      reg_rdata[CB_MODE]           = cfg_mode;
      reg_rdata[CB_BANK +: BANK_W] = cfg_bank;
    end else if (hit_stat) begin
      reg_rdata[SB_DONE] = done_flag;
      reg_rdata[SB_BUSY] = busy;
    end else if (hit_time) begin
      reg_rdata[TW-1:0] = time_q;
    end else if (hit_sup) begin
      reg_rdata[0] = supply_en;
    end else begin
      for (int k = 0; k < WPB; k++) begin
        if (bus_addr == ADDR_W'(RA_PGM + k)) reg_rdata = pgm_w[k];
      end
    end
  end

endmodule

// File: rtl/efuse_fsm.sv
module efuse_fsm
  import efuse_seq_pkg::*;
#(
  parameter int BANK_BITS = 256,
  parameter int SU_W      = 8,
  parameter int PW_W      = 16,
  parameter int RW_W      = 8,
  parameter int IDX_W     = $clog2(BANK_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode_prog,
  input  logic [SU_W-1:0]      t_su,
  input  logic [PW_W-1:0]      t_pw,
  input  logic [RW_W-1:0]      t_rw,
  input  logic [BANK_BITS-1:0] pgm_bits,
  input  logic                 fz_din,
  output logic                 busy,
  output logic [IDX_W-1:0]     bit_idx,
  output logic                 fz_prog,
  output logic                 fz_sense,
  output logic                 cap_valid,
  output logic                 cap_bit,
  output logic                 seq_done
);

  localparam int CNT_A = (SU_W > RW_W) ? SU_W : RW_W;
  localparam int CNT_W = (PW_W > CNT_A) ? PW_W : CNT_A;

  sq_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] su_load, pw_load, rw_load;
  logic             last_bit, skip_bit, cnt_zero, strobe_end;

  assign su_load   = CNT_W'(phase_load(32'(t_su)));
  assign pw_load   = CNT_W'(phase_load(32'(t_pw)));
  assign rw_load   = CNT_W'(phase_load(32'(t_rw)));
  assign last_bit  = bit_idx == IDX_W'(BANK_BITS - 1);
  assign skip_bit  = mode_prog && !pgm_bits[bit_idx];
  assign cnt_zero  = cnt == '0;
  assign strobe_end = (st == SQ_STROBE) && cnt_zero;

  assign busy      = st != SQ_IDLE;
  assign fz_prog   = (st == SQ_STROBE) && mode_prog;
  assign fz_sense  = (st == SQ_STROBE) && !mode_prog;
  assign cap_valid = strobe_end && !mode_prog;
  assign cap_bit   = fz_din;
  assign seq_done  = st == SQ_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      bit_idx <= '0;
      cnt     <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            st      <= SQ_SCAN;
            bit_idx <= '0;
          end
        end
        SQ_SCAN: begin
          if (skip_bit) begin
            if (last_bit) st <= SQ_FIN;
            else          bit_idx <= bit_idx + 1'b1;
          end else begin
            st  <= SQ_SETUP;
            cnt <= su_load;
          end
        end
        SQ_SETUP: begin
          if (cnt_zero) begin
            st  <= SQ_STROBE;
            cnt <= mode_prog ? pw_load : rw_load;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_STROBE: begin
          if (cnt_zero) begin
            if (mode_prog) begin
              st  <= SQ_HOLD;
              cnt <= su_load;
            end else if (last_bit) begin
              st <= SQ_FIN;
            end else begin
              st      <= SQ_SCAN;
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_HOLD: begin
          if (cnt_zero) begin
            if (last_bit) begin
              st <= SQ_FIN;
            end else begin
              st      <= SQ_SCAN;
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_FIN:  st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/efuse_shadow.sv
module efuse_shadow #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_BITS = 256,
  parameter int BANK_W    = 2,
  parameter int IDX_W     = $clog2(BANK_BITS),
  parameter int WSEL_W    = $clog2(BANK_BITS / 32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [31:0]       rd_data
);

  localparam int TOT   = NUM_BANKS * BANK_BITS;
  localparam int TOT_W = $clog2(TOT);

  logic [TOT-1:0]   flat;
  logic [TOT_W-1:0] rd_base;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_BITS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 q <= '0;
        else if (wr_en && wr_bank == BANK_W'(b))    q[wr_idx] <= wr_bit;
      end
      assign flat[b*BANK_BITS +: BANK_BITS] = q;
    end
  endgenerate

  assign rd_base = TOT_W'(int'(rd_bank) * BANK_BITS + int'(rd_word) * 32);
  assign rd_data = flat[rd_base +: 32];

endmodule

// File: rtl/efuse_seq.sv
module efuse_seq
  import efuse_seq_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int BANK_BITS = 256,
  parameter  int SU_W      = 8,
  parameter  int PW_W      = 16,
  parameter  int RW_W      = 8,
  localparam int WPB       = BANK_BITS / 32,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W     = $clog2(BANK_BITS),
  localparam int WSEL_W    = $clog2(WPB),
  localparam int FA_W      = BANK_W + IDX_W,
  localparam int ADDR_W    = $clog2(RA_SHADOW + NUM_BANKS * WPB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [FA_W-1:0]   fz_addr,
  output logic              fz_prog,
  output logic              fz_sense,
  input  logic              fz_din,
  output logic              fz_supply_en
);

  logic                 start, busy, seq_done, stat_w1c, done_flag;
  logic                 cfg_mode;
  logic [BANK_W-1:0]    cfg_bank;
  logic [SU_W-1:0]      t_su;
  logic [PW_W-1:0]      t_pw;
  logic [RW_W-1:0]      t_rw;
  logic [BANK_BITS-1:0] pgm_bits;
  logic [IDX_W-1:0]     bit_idx;
  logic                 cap_valid, cap_bit;
  logic                 pgm_cur_bit;
  logic [31:0]          reg_rdata, sh_rdata;
  logic                 in_shadow;
  int unsigned          sh_off;
  logic [BANK_W-1:0]    sh_bank;
  logic [WSEL_W-1:0]    sh_word;

  efuse_regs #(
    .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS), .SU_W(SU_W), .PW_W(PW_W),
    .RW_W(RW_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .seq_done(seq_done), .start(start),
    .cfg_mode(cfg_mode), .cfg_bank(cfg_bank), .t_su(t_su), .t_pw(t_pw),
    .t_rw(t_rw), .pgm_bits(pgm_bits), .supply_en(fz_supply_en),
    .done_flag(done_flag), .stat_w1c(stat_w1c), .reg_rdata(reg_rdata)
  );

  efuse_fsm #(
    .BANK_BITS(BANK_BITS), .SU_W(SU_W), .PW_W(PW_W), .RW_W(RW_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_prog(cfg_mode),
    .t_su(t_su), .t_pw(t_pw), .t_rw(t_rw), .pgm_bits(pgm_bits),
    .fz_din(fz_din), .busy(busy), .bit_idx(bit_idx), .fz_prog(fz_prog),
    .fz_sense(fz_sense), .cap_valid(cap_valid), .cap_bit(cap_bit),
    .seq_done(seq_done)
  );

  efuse_shadow #(
    .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS), .BANK_W(BANK_W),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_valid), .wr_bank(cfg_bank),
    .wr_idx(bit_idx), .wr_bit(cap_bit), .rd_bank(sh_bank), .rd_word(sh_word),
    .rd_data(sh_rdata)
  );

  assign fz_addr     = {cfg_bank, bit_idx};
  assign pgm_cur_bit = pgm_bits[bit_idx];

  assign in_shadow = int'(bus_addr) >= int'(RA_SHADOW);
  assign sh_off    = in_shadow ? (int'(bus_addr) - RA_SHADOW) : 0;
  assign sh_word   = WSEL_W'(sh_off % WPB);
  assign sh_bank   = BANK_W'(sh_off / WPB);
  assign bus_rdata = in_shadow ? sh_rdata : reg_rdata;

endmodule

// File: rtl/efuse_seq_chk.sv
module efuse_seq_chk
  import efuse_seq_pkg::*;
#(
  parameter int PW_W   = 16,
  parameter int RW_W   = 8,
  parameter int FA_W   = 10,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fz_prog,
  input logic              fz_sense,
  input logic [FA_W-1:0]   fz_addr,
  input logic              busy,
  input logic              done_flag,
  input logic              stat_w1c,
  input logic              pgm_cur_bit,
  input logic [PW_W-1:0]   t_pw,
  input logic [RW_W-1:0]   t_rw,
  input logic [BANK_W-1:0] cfg_bank
);

  logic [31:0] prun, srun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prun <= '0;
      srun <= '0;
    end else begin
      prun <= fz_prog  ? prun + 32'd1 : 32'd0;
      srun <= fz_sense ? srun + 32'd1 : 32'd0;
    end
  end

  a_r3_prog_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    fz_prog |-> pgm_cur_bit);

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fz_prog && fz_sense));

  a_r7_prog_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!fz_prog && $past(fz_prog)) |-> (prun == phase_len(32'(t_pw))));

  a_r7_sense_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!fz_sense && $past(fz_sense)) |-> (srun == phase_len(32'(t_rw))));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((fz_prog && $past(fz_prog)) || (fz_sense && $past(fz_sense))) |-> $stable(fz_addr));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !stat_w1c) |=> done_flag);

  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fz_prog && !fz_sense));

  a_r9_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_bank));

endmodule

bind efuse_seq efuse_seq_chk #(
  .PW_W(PW_W), .RW_W(RW_W), .FA_W(FA_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fz_prog(fz_prog), .fz_sense(fz_sense),
  .fz_addr(fz_addr), .busy(busy), .done_flag(done_flag), .stat_w1c(stat_w1c),
  .pgm_cur_bit(pgm_cur_bit), .t_pw(t_pw), .t_rw(t_rw), .cfg_bank(cfg_bank)
);

// File: tb/efuse_seq_test.sv
module efuse_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BB = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [9:0]  fz_addr;
  logic        fz_prog, fz_sense, fz_din, fz_supply_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  efuse_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fz_addr(fz_addr),
    .fz_prog(fz_prog), .fz_sense(fz_sense), .fz_din(fz_din),
    .fz_supply_en(fz_supply_en)
  );

  // sticky fuse macro stub
  logic [NB*BB-1:0] fuse_arr = '0;
  always @(posedge clk) if (fz_prog) fuse_arr[fz_addr] <= 1'b1;
  assign fz_din = fz_sense ? fuse_arr[fz_addr] : 1'b0;

  // bench expectations
  logic [NB*BB-1:0] exp_fuse = '0;
  logic [BB-1:0]    exp_sh [NB];
  int exp_su = 1, exp_pw = 1, exp_rw = 1;

  int total = 0, bad = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe monitor, sampled away from the active edge
  int prun = 0, srun = 0, p_pulses = 0, s_pulses = 0;
  int pw_bad = 0, rw_bad = 0, su_bad = 0, hold_bad = 0;
  int age = 0, hold_cnt = 0;
  bit after_fall = 0;
  logic prev_prog = 0;
  logic [9:0] prev_addr = '0;

  always @(negedge clk) begin
    if (fz_addr != prev_addr) begin
      if (after_fall && hold_cnt < exp_su) hold_bad++;
      after_fall = 0;
      age = 0;
    end else begin
      age++;
      if (after_fall) hold_cnt++;
    end
    if (fz_prog && !prev_prog && age < exp_su) su_bad++;
    if (!fz_prog && prev_prog) begin
      after_fall = 1;
      hold_cnt = 1;
    end
    if (fz_prog) prun++;
    else if (prun != 0) begin
      p_pulses++;
      if (prun != exp_pw) pw_bad++;
      prun = 0;
    end
    if (fz_sense) srun++;
    else if (srun != 0) begin
      s_pulses++;
      if (srun != exp_rw) rw_bad++;
      srun = 0;
    end
    prev_prog = fz_prog;
    prev_addr = fz_addr;
  end

  function automatic int plen(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a);
    #1 d = bus_rdata;
  endtask

  task automatic set_time(input int su, input int pw, input int rw);
    wr(2, {8'(rw), 16'(pw), 8'(su)});
    exp_su = plen(su); exp_pw = plen(pw); exp_rw = plen(rw);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 60000; i++) begin
      rd(1, s);
      if (s[0]) break;
    end
  endtask

  task automatic clear_done();
    wr(1, 32'h1);
  endtask

  task automatic load_pgm(input logic [BB-1:0] d);
    for (int k = 0; k < 8; k++) wr(8 + k, d[32*k +: 32]);
  endtask

  task automatic prog_bank(input int b, input logic [BB-1:0] d, input string tag);
    int p0;
    load_pgm(d);
    p0 = p_pulses;
    pw_bad = 0; su_bad = 0; hold_bad = 0;
    wr(0, (32'(b) << 8) | 32'h3);
    wait_done();
    exp_fuse[b*BB +: BB] = exp_fuse[b*BB +: BB] | d;
    check(p_pulses - p0 == $countones(d), {tag, " R3 strobe count"},
          32'(p_pulses - p0), 32'($countones(d)));
    check(fuse_arr == exp_fuse, {tag, " R3 fuse array"}, 32'($countones(fuse_arr ^ exp_fuse)), 0);
    check(pw_bad == 0, {tag, " R7 program width"}, 32'(pw_bad), 0);
    check(su_bad == 0 && hold_bad == 0, {tag, " R8 setup/hold"}, 32'(su_bad + hold_bad), 0);
    clear_done();
  endtask

  task automatic read_bank(input int b, input string tag);
    int p0;
    logic [31:0] v;
    int miss;
    p0 = p_pulses;
    rw_bad = 0;
    wr(0, (32'(b) << 8) | 32'h1);
    wait_done();
    exp_sh[b] = exp_fuse[b*BB +: BB];
    check(p_pulses == p0, {tag, " R3 no burn on read"}, 32'(p_pulses - p0), 0);
    check(rw_bad == 0, {tag, " R7 sense width"}, 32'(rw_bad), 0);
    miss = 0;
    for (int bb = 0; bb < NB; bb++)
      for (int k = 0; k < 8; k++) begin
        rd(32 + 8*bb + k, v);
        if (v !== exp_sh[bb][32*k +: 32]) begin
          miss++;
          $display("FAIL %s R4 shadow bank %0d word %0d actual=%h expected=%h",
                   tag, bb, k, v, exp_sh[bb][32*k +: 32]);
        end
      end
    total++;
    if (miss != 0) bad++;
    clear_done();
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [BB-1:0] d;
    int miss;
    void'($urandom(32'd4242));
    for (int b = 0; b < NB; b++) exp_sh[b] = '0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1, v); check(v == 0, "R1 status", v, 0);
    rd(0, v); check(v == 0, "R1 control", v, 0);
    rd(3, v); check(v == 0, "R1 supply reg", v, 0);
    check(!fz_prog && !fz_sense && !fz_supply_en, "R1 outputs low",
          {29'd0, fz_prog, fz_sense, fz_supply_en}, 0);
    miss = 0;
    for (int a = 32; a < 64; a++) begin rd(a, v); if (v != 0) miss++; end
    check(miss == 0, "R1 shadow cleared", 32'(miss), 0);

    // R10 supply enable
    wr(3, 32'h1);
    check(fz_supply_en == 1'b1, "R10 supply on", 32'(fz_supply_en), 1);

    // R5 bit mapping, directed
    set_time(2, 7, 3);
    d = '0;
    d[64 +: 8] = 8'hA5;
    d[255] = 1'b1;
    prog_bank(1, d, "dir");
    check(fuse_arr[256+64 +: 8] == 8'hA5, "R5 byte0 of word2", 32'(fuse_arr[256+64 +: 8]), 32'hA5);
    read_bank(1, "dir");
    rd(32 + 8 + 2, v); check(v == 32'h0000_00A5, "R5 shadow word2", v, 32'hA5);
    rd(32 + 8 + 7, v); check(v == 32'h8000_0000, "R5 shadow word7", v, 32'h8000_0000);

    // R6 done sticky / write-1-clear
    wr(0, 32'h1);
    wait_done();
    rd(1, v); check(v[0] == 1'b1, "R6 done set", v, 1);
    rd(1, v); check(v[0] == 1'b1, "R6 done held", v, 1);
    wr(1, 32'h0);
    rd(1, v); check(v[0] == 1'b1, "R6 write 0 keeps", v, 1);
    wr(1, 32'h1);
    rd(1, v); check(v[0] == 1'b0, "R6 write 1 clears", v, 0);
    exp_sh[0] = exp_fuse[0 +: BB];

    // R9 busy and locked configuration
    d = '0;
    d[31:0] = 32'h0000_0011;
    d[160 +: 32] = 32'h0000_0003;
    load_pgm(d);
    begin
      int p0;
      p0 = p_pulses;
      wr(0, 32'h203);
      rd(1, v); check(v[1] == 1'b1, "R9 busy flag", v, 2);
      wr(8, 32'hFFFF_FFFF);
      wr(0, 32'h0);
      wr(2, 32'h0);
      wait_done();
      exp_fuse[2*BB +: BB] = exp_fuse[2*BB +: BB] | d;
      check(p_pulses - p0 == 4, "R9 op unaffected", 32'(p_pulses - p0), 4);
      rd(8, v); check(v == 32'h11, "R9 data write ignored", v, 32'h11);
      rd(0, v); check(v == 32'h202, "R9 control write ignored", v, 32'h202);
      rd(2, v); check(v == {8'd3, 16'd7, 8'd2}, "R9 timing write ignored", v, {8'd3, 16'd7, 8'd2});
      rd(1, v); check(v[1] == 1'b0, "R9 busy clears", v, 1);
      clear_done();
    end
    read_bank(2, "busy");

    // R7 zero fields behave as one cycle
    set_time(0, 0, 0);
    d = '0; d[3] = 1'b1; d[200] = 1'b1;
    prog_bank(3, d, "zero");
    read_bank(3, "zero");

    // random rounds
    for (int r = 0; r < 6; r++) begin
      int b;
      b = int'($urandom % NB);
      set_time(int'($urandom % 4), 1 + int'($urandom % 9), int'($urandom % 5));
      for (int k = 0; k < 8; k++) d[32*k +: 32] = $urandom & $urandom & $urandom;
      prog_bank(b, d, "rand");
      read_bank(b, "rand");
    end

    // long program strobe and sense strobe
    set_time(3, 1200, 60);
    d = '0; d[0] = 1'b1; d[100] = 1'b1; d[254] = 1'b1;
    prog_bank(0, d, "long");
    read_bank(0, "long");

    wr(3, 32'h0);
    check(fz_supply_en == 1'b0, "R10 supply off", 32'(fz_supply_en), 0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule